// File: doc/BRIEF.md
# Bus Access Timeout Watchdog

This block sits beside a processor bus and watches the data-enable strobe that the processor holds active for the whole of each access. While the strobe is active, a 5-bit down counter, preset from a configuration field, decrements once per clock. If the access is still open when the configured number of cycles has elapsed, the block can complete the stuck access by forcing a one-cycle ready reply, and it can signal a bus error to an interrupt controller.

Each time the strobe goes inactive the counter is preset again, so every access gets the full timeout. The bus-error output is active low and takes one of two styles: a single-cycle pulse, or a level that stays low until an acknowledge input clears it. A timeout value of zero turns detection off.

Top module: `bus_watch_timer`

## Requirements
- R1: After a synchronous reset, `force_rdy` is 0 and `bus_err_n` is 1.
- R2: When `bus_active` is sampled high on N consecutive rising edges (N = `cfg_limit`, 1 to 31, taken as it was on the last edge where `bus_active` was low), `force_rdy` is 1 during the clock cycle that follows the Nth of those edges, provided `cfg_rdy_en` is 1.
- R3: If `bus_active` is sampled low before the Nth consecutive high edge, no timeout occurs, and the next access is again given the full N cycles.
- R4: A timeout fires at most once per interval of `bus_active` being high; `force_rdy` is never high for two cycles in a row.
- R5: With `cfg_rdy_en` = 0 `force_rdy` stays 0 at a timeout; with `cfg_err_en` = 0 `bus_err_n` stays 1 at a timeout.
- R6: With `cfg_level` = 0 (pulse style), a timeout drives `bus_err_n` low for exactly the one cycle in which `force_rdy` would be high.
- R7: With `cfg_level` = 1 (held style), a timeout drives `bus_err_n` low from that cycle on; it returns to 1 in the cycle after an edge where `err_ack` is sampled 1 and no new timeout occurs on that edge (a new timeout wins over the acknowledge).
- R8: With `cfg_limit` = 0, no timeout ever occurs, however long `bus_active` is held.
- R9: `err_ack` has no effect on `bus_err_n` while no held-style error is pending.
- R10: A change of `cfg_limit` while `bus_active` is high does not alter the access in progress; it applies from the next preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_active | input | 1 | Processor data-enable, high while an access is open |
| cfg_limit | input | 5 | Timeout in clock cycles; 0 disables |
| cfg_err_en | input | 1 | Allow bus-error signalling |
| cfg_rdy_en | input | 1 | Allow forced ready reply |
| cfg_level | input | 1 | Error style: 0 pulse, 1 held until acknowledged |
| err_ack | input | 1 | Clears a held-style error |
| force_rdy | output | 1 | One-cycle forced ready at a timeout |
| bus_err_n | output | 1 | Bus-error output, active low |

## Verification
Both outputs are registered once after the edge that completes the Nth high sample, so a timeout is due in the cycle after that edge, and an acknowledge takes effect one cycle after the edge that samples it. The bench drives inputs on the falling edge, advances a reference model on the rising edge from the same sampled inputs, and compares the outputs at the next falling edge, which is exactly the cycle in which a result is due. Directed sequences count rising edges explicitly to check the aborted access, the zero limit, the mid-access limit change and the acknowledge priority at their expected cycles.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  localparam int unsigned LIMIT_W = 5;

  typedef enum logic {
    ERR_PULSE = 1'b0,
    ERR_HOLD  = 1'b1
  } err_style_e;
endpackage

// File: rtl/bwt_countdown.sv
module bwt_countdown #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic         hit
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic         done_q;

  // Expiry: access open, not yet fired, last cycle of the window.
  assign hit = active && !done_q && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= limit;
      done_q <= 1'b0;
    end else if (!active) begin
      cnt_q  <= limit;
      done_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= ZERO;
      done_q <= 1'b1;
    end else if (!done_q && cnt_q != ZERO) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // R8: a zero preset can never expire on the following cycle
  p_zero_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (!active && limit == ZERO) |=> !hit);

  // R4: no second expiry right after one
  p_once_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/bwt_errout.sv
module bwt_errout
  import bwt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       err_en,
  input  err_style_e style,
  input  logic       ack,
  output logic       err_n
);
  logic hold_q;
  logic pulse_q;
  logic set_hold;
  logic set_pulse;

  assign set_hold  = hit && err_en && (style == ERR_HOLD);
  assign set_pulse = hit && err_en && (style == ERR_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= set_pulse;
      if (set_hold)
        hold_q <= 1'b1;
      else if (ack)
        hold_q <= 1'b0;
    end
  end

  assign err_n = ~(hold_q | pulse_q);

  // R7: a held error persists until acknowledged
  p_hold_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !ack) |=> hold_q);

  // R6: a pulse-style error lasts one cycle
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/bus_watch_timer.sv
module bus_watch_timer
  import bwt_pkg::*;
#(
  parameter int unsigned CNT_W = LIMIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_active,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             cfg_err_en,
  input  logic             cfg_rdy_en,
  input  logic             cfg_level,
  input  logic             err_ack,
  output logic             force_rdy,
  output logic             bus_err_n
);
  logic       hit;
  logic       rdy_q;
  err_style_e style;

  assign style = err_style_e'(cfg_level);

  bwt_countdown #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .active (bus_active),
    .limit  (cfg_limit),
    .hit    (hit)
  );

  bwt_errout u_err (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .err_en (cfg_err_en),
    .style  (style),
    .ack    (err_ack),
    .err_n  (bus_err_n)
  );

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= hit && cfg_rdy_en;
  end

  assign force_rdy = rdy_q;

  // R2: a forced ready only follows an edge with the access open
  p_rdy_needs_access_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(force_rdy) |-> $past(bus_active));

  // R4: ready is a single-cycle pulse
  p_rdy_single_r4: assert property (@(posedge clk) disable iff (rst)
    force_rdy |=> !force_rdy);

  // R5: ready stays low when its enable was off
  p_rdy_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdy_en |=> !force_rdy);
endmodule

// File: tb/tb_bus_watch_timer.sv
module tb_bus_watch_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_active;
  logic [4:0] cfg_limit;
  logic       cfg_err_en, cfg_rdy_en, cfg_level, err_ack;
  logic       force_rdy, bus_err_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bus_watch_timer dut (
    .clk(clk), .rst(rst), .bus_active(bus_active), .cfg_limit(cfg_limit),
    .cfg_err_en(cfg_err_en), .cfg_rdy_en(cfg_rdy_en), .cfg_level(cfg_level),
    .err_ack(err_ack), .force_rdy(force_rdy), .bus_err_n(bus_err_n)
  );

  // Reference model from the requirements: run length of high samples.
  int   run, lim;
  logic fired, hold, e_rdy, e_berr_n;
  logic s_rdy_en, s_err_en, s_level, s_zero, s_second;

  function automatic logic expires(logic act, logic f, int r, int l);
    return act && !f && l != 0 && (r + 1 == l);
  endfunction

  always @(posedge clk) begin
    logic fire;
    if (rst) begin
      run = 0; lim = int'(cfg_limit); fired = 1'b0; hold = 1'b0;
      e_rdy = 1'b0; e_berr_n = 1'b1; s_second = 1'b0;
    end else begin
      fire = expires(bus_active, fired, run, lim);
      s_rdy_en = cfg_rdy_en; s_err_en = cfg_err_en; s_level = cfg_level;
      s_zero = (lim == 0); s_second = fired && bus_active;
      e_rdy = fire && cfg_rdy_en;
      if (fire && cfg_err_en && cfg_level) hold = 1'b1;
      else if (err_ack) hold = 1'b0;
      e_berr_n = !(hold || (fire && cfg_err_en && !cfg_level));
      if (!bus_active) begin
        run = 0; fired = 1'b0; lim = int'(cfg_limit);
      end else if (fire) fired = 1'b1;
      else if (run < 63) run = run + 1;
    end
  end

  task automatic check(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Continuous comparison against the model, one cycle after each edge.
  logic run_cmp = 1'b0;
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      check(!s_rdy_en ? "R5" : s_zero ? "R8" : s_second ? "R4" : "R2",
            force_rdy, e_rdy);
      check(!s_err_en ? "R5" : s_level ? "R7" : "R6", bus_err_n, e_berr_n);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_active = 1'b0; cfg_limit = 5'd5; cfg_err_en = 1'b1;
    cfg_rdy_en = 1'b1; cfg_level = 1'b0; err_ack = 1'b0;
    void'($urandom(32'd20240611));
    step(3);
    check("R1", force_rdy, 1'b0);
    check("R1", bus_err_n, 1'b1);
    rst = 1'b0;
    run_cmp = 1'b1;
    step(2);

    // R3: abort after 3 of 5, then a full access fires after 5 edges
    bus_active = 1'b1; step(3);
    bus_active = 1'b0; step(1);
    bus_active = 1'b1; step(4);
    check("R3", force_rdy, 1'b0);
    step(1);
    check("R3", force_rdy, 1'b1);
    check("R6", bus_err_n, 1'b0);
    step(1);
    check("R6", bus_err_n, 1'b1);
    check("R4", force_rdy, 1'b0);
    step(20);
    check("R4", force_rdy, 1'b0);
    bus_active = 1'b0; step(2);

    // R10: limit raised mid-access has no effect on it
    cfg_limit = 5'd3; step(1);
    bus_active = 1'b1; step(1);
    cfg_limit = 5'd9; step(2);
    check("R10", force_rdy, 1'b1);
    bus_active = 1'b0; step(2);

    // R8: zero limit never fires
    cfg_limit = 5'd0; step(1);
    bus_active = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        step(1);
        if (force_rdy || !bus_err_n) seen++;
      end
      check("R8", seen != 0, 1'b0);
    end
    bus_active = 1'b0; step(2);

    // R9: acknowledge with nothing pending
    err_ack = 1'b1; step(2);
    check("R9", bus_err_n, 1'b1);
    err_ack = 1'b0;

    // R7: held error, then ack coinciding with a new timeout
    cfg_level = 1'b1; cfg_limit = 5'd2; step(1);
    bus_active = 1'b1; step(2);
    check("R7", bus_err_n, 1'b0);
    bus_active = 1'b0; step(6);
    check("R7", bus_err_n, 1'b0);
    bus_active = 1'b1; step(1);
    err_ack = 1'b1; step(1);
    check("R7", bus_err_n, 1'b0);
    err_ack = 1'b1; step(1);
    check("R7", bus_err_n, 1'b1);
    err_ack = 1'b0; bus_active = 1'b0; step(2);

    // R5: enables off
    cfg_level = 1'b0; cfg_err_en = 1'b0; cfg_rdy_en = 1'b0; step(1);
    bus_active = 1'b1; step(2);
    check("R5", force_rdy, 1'b0);
    check("R5", bus_err_n, 1'b1);
    bus_active = 1'b0; step(2);

    // Random traffic compared cycle by cycle against the model
    for (int b = 0; b < 400; b++) begin
      cfg_limit  = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 8);
      cfg_err_en = ($urandom % 5) != 0;
      cfg_rdy_en = ($urandom % 5) != 0;
      cfg_level  = $urandom % 2;
      bus_active = 1'b1;
      for (int i = 0; i < int'($urandom % 14); i++) begin
        err_ack = ($urandom % 8) == 0;
        if (($urandom % 16) == 0) cfg_limit = 5'($urandom % 8);
        step(1);
      end
      bus_active = 1'b0;
      for (int i = 0; i < 1 + int'($urandom % 3); i++) begin
        err_ack = ($urandom % 4) == 0;
        step(1);
      end
      err_ack = 1'b0;
    end

    run_cmp = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule